// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block drives a small configuration EEPROM over a three-wire serial link made of a chip select, a shift clock and a data line into the device. A fourth line, the data line out of the device, is read back. A host presents one request: an operation, a 6-bit word address and a 16-bit word. The engine then sends a fixed 27-bit frame most significant bit first and collects the bits returned on the device's output line. When the frame is complete it raises `done` for one cycle. The word assembled from the last sixteen sampled bits is valid at that point.

Every phase of the link lasts the same programmable number of cycles. This covers the chip-select setup, each high and each low half of the shift clock, the chip-select hold and the idle gap after deselect. The delay value is captured when a request is accepted. The controller is a single state machine with seven states:

- `ST_IDLE`: waiting for a request.
- `ST_SETUP`: chip select is high and the clock is low, before the first rising edge.
- `ST_CLK_HI`: the clock is high.
- `ST_CLK_LO`: the clock is low between bits.
- `ST_HOLD`: chip select stays high after the last falling edge.
- `ST_GAP`: chip select is low before the engine can be reused.
- `ST_FINISH`: `done` is pulsed.

The machine makes these transitions:

- IDLE→SETUP on an accepted request.
- SETUP→CLK_HI and CLK_LO→CLK_HI on a timer tick. The device output is sampled on these transitions.
- CLK_HI→CLK_LO on a tick when bits remain. The next bit is presented at this point.
- CLK_HI→HOLD on a tick after bit 27.
- HOLD→GAP on a tick.
- GAP→FINISH on a tick.
- FINISH→IDLE unconditionally.

Top module: `tw_eeprom_engine`

## Requirements
- R1: While reset is low, and in the first cycle after reset falls, the outputs `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all 0. A reset in the middle of a transaction drops chip select and the clock immediately.
- R2: Each transaction produces exactly 27 rising edges of `ee_sk`. The bits on `ee_di` at those edges are, in order:
  - a 0;
  - a 1;
  - the two `req_op` bits, high bit first;
  - the six address bits, high bit first;
  - a 0;
  - sixteen data bits, high bit first.
- R3: The `req_op` encoding is 2'b01 write, 2'b10 read and 2'b11 erase. It is sent as given, so the command field reads 101, 110 or 111. The data field carries `req_wdata` only for a write and is all zeros for a read or an erase. A request with `req_op` 2'b00 is ignored: `busy` stays 0 and `ee_cs` stays 0.
- R4: Every high half and every low half of `ee_sk` lasts exactly `half_delay`+1 cycles. The value used is the one present at acceptance, and later changes to `half_delay` have no effect on a running transaction.
- R5: `ee_di` changes only while `ee_sk` is low and holds steady through every high phase.
- R6: The following three intervals each last `half_delay`+1 cycles:
  - from `ee_cs` rising to the first `ee_sk` rising edge;
  - from the last `ee_sk` falling edge to `ee_cs` falling;
  - from `ee_cs` falling to `done`.

  `ee_sk` is never high while `ee_cs` is low.
- R7: `ee_do` is sampled on each rising edge of `ee_sk`. When `done` is high, `rd_data` holds the last 16 sampled bits, the first sampled of these in bit 15. `rd_data` keeps this value until the next request is accepted.
- R8: `busy` is 1 from the cycle after acceptance up to and including the `done` cycle. `done` is high for exactly one cycle. Both are 0 in the cycle after `done`.
- R9: A request presented while `busy` is 1 is ignored. The running frame is unchanged, and no new transaction starts after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken in `ST_IDLE` only |
| req_op | input | 2 | Operation: 01 write, 10 read, 11 erase, 00 none |
| req_addr | input | ADDR_W | EEPROM word address |
| req_wdata | input | DATA_W | Word to write (write only) |
| half_delay | input | DLY_W | Phase length minus one, in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | DATA_W | Word read from the device |
| ee_cs | output | 1 | Chip select to the device |
| ee_sk | output | 1 | Shift clock to the device |
| ee_di | output | 1 | Serial data into the device |
| ee_do | input | 1 | Serial data out of the device |

## Verification
The situations that are hard to reach from the ports are a second request, and a change of `half_delay`, arriving in the middle of a running frame. Both have to land while the engine is busy and leave no trace. The sweep therefore re-runs transactions with a one-cycle request for an erase to all-ones addresses, together with a larger delay, injected ten cycles into the frame. The bench then checks that the frame bits, every phase length and the idle state after `done` match the original request. Read data depends on a responder model that answers only after the dummy bit. That model drives its word on falling clock edges, so the value expected in `rd_data` is fixed by the bit count alone.

// File: rtl/tw_eep_pkg.sv
package tw_eep_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } ee_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_HOLD,
        ST_GAP,
        ST_FINISH
    } ee_state_e;

endpackage

// File: rtl/tw_eep_pace.sv
// Phase timer: one tick every (latched half_delay + 1) cycles while running.
module tw_eep_pace #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] half_in,
    input  logic             run,
    output logic             tick
);
    logic [DLY_W-1:0] hd_q;
    logic [DLY_W-1:0] cnt_q;

    assign tick = run && (cnt_q == hd_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (load) begin
                hd_q <= half_in;
            end
            if (load || !run || tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_PACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= hd_q)) else $error("phase counter overran");  // R4

endmodule

// File: rtl/tw_eep_shift.sv
// Frame shifter: outgoing frame register and incoming word register.
module tw_eep_shift
    import tw_eep_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              advance,
    input  logic              capture,
    input  logic              ee_do,
    output logic              di_bit,
    output logic              last_bit,
    output logic [DATA_W-1:0] rd_word
);
    localparam int IDX_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] tx_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  rx_q;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  data_field;

    assign data_field = (ee_op_e'(op) == OP_WRITE) ? wdata : '0;
    assign frame      = {1'b0, 1'b1, op, addr, 1'b0, data_field};

    assign di_bit   = tx_q[FRAME_W-1];
    assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
    assign rd_word  = rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            idx_q <= '0;
            rx_q  <= '0;
        end else if (load) begin
            tx_q  <= frame;
            idx_q <= '0;
            rx_q  <= '0;
        end else begin
            if (advance) begin
                tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
            if (capture) begin
                rx_q <= {rx_q[DATA_W-2:0], ee_do};
            end
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(FRAME_W - 1)) else $error("bit index past frame");  // R2

    AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last_bit) else $error("shift after final bit");  // R2

endmodule

// File: rtl/tw_eep_seq.sv
// Transaction sequencer: state register, next-state logic, decoded outputs.
module tw_eep_seq
    import tw_eep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       tick,
    input  logic       last_bit,
    output logic       accept,
    output logic       advance,
    output logic       capture,
    output logic       pace_run,
    output logic       cs,
    output logic       sk,
    output logic       di_en,
    output logic       busy,
    output logic       done
);
    ee_state_e state_q;
    ee_state_e state_d;

    assign accept = (state_q == ST_IDLE) && req_valid && (ee_op_e'(req_op) != OP_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  if (tick) state_d = ST_CLK_HI;
            ST_CLK_HI: if (tick) state_d = last_bit ? ST_HOLD : ST_CLK_LO;
            ST_CLK_LO: if (tick) state_d = ST_CLK_HI;
            ST_HOLD:   if (tick) state_d = ST_GAP;
            ST_GAP:    if (tick) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cs       = 1'b0;
        sk       = 1'b0;
        di_en    = 1'b0;
        pace_run = 1'b0;
        capture  = 1'b0;
        advance  = 1'b0;
        busy     = (state_q != ST_IDLE);
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                cs = 1'b1; di_en = 1'b1; pace_run = 1'b1; capture = tick;
            end
            ST_CLK_HI: begin
                cs = 1'b1; sk = 1'b1; di_en = 1'b1; pace_run = 1'b1;
                advance = tick && !last_bit;
            end
            ST_CLK_LO: begin
                cs = 1'b1; di_en = 1'b1; pace_run = 1'b1; capture = tick;
            end
            ST_HOLD: begin
                cs = 1'b1; pace_run = 1'b1;
            end
            ST_GAP: begin
                pace_run = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && ee_op_e'(req_op) == OP_NONE)
        |=> (state_q == ST_IDLE)) else $error("null op started a frame");  // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy) else $error("busy dropped early");  // R9

    AST_FINISH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE)) else $error("no return to idle");  // R8

endmodule

// File: rtl/tw_eeprom_engine.sv
module tw_eeprom_engine #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DLY_W-1:0]  half_delay,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W = 1 + 3 + ADDR_W + 1 + DATA_W;
    localparam int RISE_W  = $clog2(FRAME_W + 1);

    logic accept, advance, capture, pace_run, tick;
    logic last_bit, di_bit, di_en;

    tw_eep_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_op   (req_op),
        .tick     (tick),
        .last_bit (last_bit),
        .accept   (accept),
        .advance  (advance),
        .capture  (capture),
        .pace_run (pace_run),
        .cs       (ee_cs),
        .sk       (ee_sk),
        .di_en    (di_en),
        .busy     (busy),
        .done     (done)
    );

    tw_eep_pace #(.DLY_W(DLY_W)) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .half_in(half_delay),
        .run    (pace_run),
        .tick   (tick)
    );

    tw_eep_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .op      (req_op),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .advance (advance),
        .capture (capture),
        .ee_do   (ee_do),
        .di_bit  (di_bit),
        .last_bit(last_bit),
        .rd_word (rd_data)
    );

    assign ee_di = di_en & di_bit;

    // Edge counter used only by the checks below.
    logic              sk_q;
    logic [RISE_W-1:0] rises_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q    <= 1'b0;
            rises_q <= '0;
        end else begin
            sk_q <= ee_sk;
            if (accept) begin
                rises_q <= '0;
            end else if (ee_sk && !sk_q) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rises_q == RISE_W'(FRAME_W))) else $error("wrong edge count");  // R2

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs) else $error("clock outside select");  // R6

    AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di)) else $error("data moved while clock high");  // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle");  // R8

    AST_DONE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !ee_cs)) else $error("done outside busy");  // R8

endmodule

// File: tb/test_tw_eeprom_engine.sv
module test_tw_eeprom_engine;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int LW = 8;
    localparam int FW = 27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LW-1:0] half_delay = '0;
    logic          busy, done, ee_cs, ee_sk, ee_di;
    logic [DW-1:0] rd_data;
    logic          ee_do = 1'b0;

    tw_eeprom_engine #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW)) i_tw_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .half_delay(half_delay),
        .busy(busy), .done(done), .rd_data(rd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int errors = 0;

    // Link monitor and responder state.
    int cyc = 0;
    int rises = 0;
    logic [FW-1:0] got_frame = '0;
    int t_cs_rise = 0, t_first_rise = 0, t_last_edge = 0, t_last_fall = 0;
    int t_cs_fall = 0, t_done = 0, seg_bad = 0, di_bad = 0;
    int exp_len = 1;
    logic [DW-1:0] dev_word = '0;
    logic sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ee_cs && !cs_p) begin
                t_cs_rise = cyc; rises = 0; got_frame = '0;
                seg_bad = 0; di_bad = 0; t_last_edge = cyc; ee_do = 1'b0;
            end
            if (ee_sk && !sk_p) begin
                rises++;
                got_frame = {got_frame[FW-2:0], ee_di};
                if (rises == 1) t_first_rise = cyc;
                else if (cyc - t_last_edge != exp_len) seg_bad++;
                t_last_edge = cyc;
            end
            if (!ee_sk && sk_p) begin
                if (cyc - t_last_edge != exp_len) seg_bad++;
                t_last_edge = cyc;
                t_last_fall = cyc;
                ee_do = (rises >= 11 && rises <= 26) ? dev_word[26 - rises] : 1'b0;
            end
            if (ee_sk && sk_p && ee_di != di_p) di_bad++;
            if (!ee_cs && cs_p) t_cs_fall = cyc;
            if (done) t_done = cyc;
        end
        sk_p = ee_sk; cs_p = ee_cs; di_p = ee_di;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] op, input int addr, input logic [DW-1:0] data,
                           input logic [DW-1:0] word, input int hd, input bit poke);
        logic [FW-1:0] exp_frame;
        int n;
        @(negedge clk);
        dev_word = word; exp_len = hd + 1; half_delay = LW'(hd);
        req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
        chk("R8", "busy after accept", busy, 1);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin
                req_valid = 1'b1; req_op = 2'b11; req_addr = '1; req_wdata = '1;
                half_delay = LW'(hd + 5);
            end
            if (poke && n == 11) req_valid = 1'b0;
        end
        chk("R8", "done reached", (n < 20000), 1);
        chk("R8", "busy at done", busy, 1);
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        chk("R8", "busy after done", busy, 0);
        exp_frame = {1'b0, 1'b1, op, AW'(addr), 1'b0, (op == 2'b01) ? data : 16'h0000};
        chk("R2 R3", "frame bits", got_frame, exp_frame);
        chk("R2", "clock rises", rises, FW);
        chk("R4", "bad phase lengths", seg_bad, 0);
        chk("R5", "data moves in high phase", di_bad, 0);
        chk("R6", "select setup", t_first_rise - t_cs_rise, hd + 1);
        chk("R6", "select hold", t_cs_fall - t_last_fall, hd + 1);
        chk("R6", "deselect gap", t_done - t_cs_fall, hd + 1);
        if (op == 2'b10) chk("R7", "read word", rd_data, word);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk("R9", "no second frame cs", ee_cs, 0);
            chk("R9", "no second frame busy", busy, 0);
            half_delay = LW'(hd);
        end
    endtask

    initial begin
        repeat (20000 * 7) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {ee_cs, ee_sk, ee_di, busy, done}, 0);

        // R3: null operation ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = 6'h15;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "null op busy", busy, 0);
        chk("R3", "null op select", ee_cs, 0);
        @(negedge clk);
        chk("R3", "null op select later", ee_cs, 0);

        // Sweep: every address at the shortest delay, strided at longer ones.
        for (int hd = 0; hd < 4; hd += (hd == 0) ? 1 : 2) begin
            for (int op = 1; op < 4; op++) begin
                for (int a = 0; a < 64; a += (hd == 0) ? 1 : 9) begin
                    run_txn(2'(op), a, DW'(a * 16'h0403) ^ 16'hA55A,
                            ~(DW'(a * 16'h0111) ^ 16'h3C96), hd, 1'b0);
                end
            end
        end

        // R9 and R4: request and delay change while busy.
        run_txn(2'b10, 6'h2A, 16'h1234, 16'hBEEF, 2, 1'b1);
        run_txn(2'b01, 6'h01, 16'hF00D, 16'h0000, 0, 1'b1);
        run_txn(2'b11, 6'h3F, 16'hFFFF, 16'h8001, 1, 1'b1);

        // R1: reset in mid-frame
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b10; req_addr = 6'h07; half_delay = 8'd1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid-frame reset", {ee_cs, ee_sk, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", {ee_cs, ee_sk, ee_di, busy}, 0);
        run_txn(2'b10, 6'h07, 16'h0, 16'h5AA5, 1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule